// File: doc/BRIEF.md
# Serial Port Pin Reassignment Multiplexer

This block holds one 32-bit control word, written and read over a simple register bus. It uses that word to decide which physical pins carry the signals of two serial ports. Port 1 hosts a UART engine and an SDLC engine. Port 4 hosts an SSP engine and a codec-port engine.

Each port has a set of dedicated pins. Normally a port's protocol-select inputs pick which of its engines drives those pins. When the port's reassign flag is set, the port's select inputs no longer matter. The dedicated pins are handed to the port's alternate engine, and the other engine moves onto a fixed group of general-purpose pins. The general-purpose pin unit sits outside this block. Its drive, enable and input values pass through the block unchanged, except on pins that a set flag takes over. For those pins the block raises a per-pin override indication.

The register write is the only clocked path. All pin routing is combinational from the registered flags and the live select inputs.

Top module: `sport_pin_router`

## Requirements
- R1: After reset both reassign flags are 0. The control word reads back as 0, and every general-purpose pin output, enable and override equals the pass-through value (override 0).
- R2: A write (`reg_sel`=1, `reg_we`=1, `reg_addr`=0) loads bit 12 as the UART reassign flag and bit 18 as the SSP reassign flag. The new value is visible from the clock edge that samples the strobe, not before. Reads at address 0 return the flags at bits 12 and 18 and 0 in every other bit.
- R3: A cycle with no write strobe, or a write to any address other than 0, leaves both flags unchanged. Reads at any other address return 0.
- R4: With the UART flag at 0, `p1_sel_uart`=1 places the UART on the dedicated port-1 pins, and `p1_sel_uart`=0 places the SDLC engine there. Only the selected engine's active indication is 1. The unselected engine's receive output idles at 1. The dedicated transmit enable is 1.
- R5: With the UART flag at 1, `p1_sel_uart` is ignored and SDLC uses the dedicated port-1 pins. UART transmit drives general pin 14 with its enable at 1. UART receive samples general pin 15, whose enable is 0 and drive 0. Both port-1 active indications are 1.
- R6: With the SSP flag at 0, codec enable has precedence. `p4_codec_en`=1 puts the codec engine on the dedicated port-4 pins whatever `p4_ssp_en` is. The SSP engine uses those pins only for codec enable 0 and SSP enable 1.
- R7: With the SSP flag at 0 and both enables at 0, the dedicated port-4 pins idle: transmit 1, clock 0, frame 0, enable 0. Both port-4 active indications are 0 and both engine receive outputs are 1.
- R8: With the SSP flag at 1, both enables are ignored and the codec engine uses the dedicated port-4 pins. SSP transmit, clock and frame drive general pins 10, 12 and 13 with enable 1. SSP receive samples general pin 11, whose enable is 0 and drive 0.
- R9: `gp_ovr_o` is 1 on exactly pins 14 and 15 when the UART flag is set, and on exactly pins 10 to 13 when the SSP flag is set. Every pin without override carries `gp_out_i` and `gp_oe_i` unchanged.
- R10: Routing follows changes of the select and engine inputs within the same cycle, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | Register access select |
| reg_we | input | 1 | Write strobe |
| reg_addr | input | ADDR_W | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data |
| p1_sel_uart | input | 1 | Port-1 protocol select, 1 = UART |
| uart_txd | input | 1 | UART engine transmit |
| sdlc_txd | input | 1 | SDLC engine transmit |
| uart_rxd | output | 1 | UART engine receive |
| sdlc_rxd | output | 1 | SDLC engine receive |
| p1_uart_act | output | 1 | UART engine has pins |
| p1_sdlc_act | output | 1 | SDLC engine has pins |
| p1_pin_tx | output | 1 | Dedicated port-1 transmit pin |
| p1_pin_oe | output | 1 | Dedicated port-1 transmit enable |
| p1_pin_rx | input | 1 | Dedicated port-1 receive pin |
| p4_codec_en | input | 1 | Codec engine enable (priority) |
| p4_ssp_en | input | 1 | SSP engine enable |
| codec_txd | input | 1 | Codec engine transmit |
| codec_sclk | input | 1 | Codec engine serial clock |
| codec_sfrm | input | 1 | Codec engine frame |
| ssp_txd | input | 1 | SSP engine transmit |
| ssp_sclk | input | 1 | SSP engine serial clock |
| ssp_sfrm | input | 1 | SSP engine frame |
| codec_rxd | output | 1 | Codec engine receive |
| ssp_rxd | output | 1 | SSP engine receive |
| p4_codec_act | output | 1 | Codec engine has pins |
| p4_ssp_act | output | 1 | SSP engine has pins |
| p4_pin_tx | output | 1 | Dedicated port-4 transmit pin |
| p4_pin_clk | output | 1 | Dedicated port-4 clock pin |
| p4_pin_frm | output | 1 | Dedicated port-4 frame pin |
| p4_pin_oe | output | 1 | Enable of the three port-4 output pins |
| p4_pin_rx | input | 1 | Dedicated port-4 receive pin |
| gp_out_i | input | GPIO_W | Drive values from the general-purpose unit |
| gp_oe_i | input | GPIO_W | Enables from the general-purpose unit |
| gp_in_i | input | GPIO_W | Sampled general-purpose pin levels |
| gp_out_o | output | GPIO_W | Drive values to the pads |
| gp_oe_o | output | GPIO_W | Enables to the pads |
| gp_ovr_o | output | GPIO_W | Per-pin override indication |

## Verification
The bound checker watches several relations on every cycle:
- a write reaching the override indications one edge later;
- the flags staying put without a write;
- codec priority and the idle levels on port 4;
- the fixed pin directions under each reassignment;
- the pass-through of every pin that is not overridden.

Some behaviour only the bench scenarios can show. These are the bit positions seen through register readback, the ignored reserved bits, and the absence of any effect before the write edge. The same holds for the same-cycle response to select changes. The bench sweeps all four flag settings against every combination of port selects, enables, engine data polarity and two pin patterns.

// File: rtl/sport_pin_pkg.sv
package sport_pin_pkg;

   localparam int unsigned CSR_W = 32;

   // Three output lines of a synchronous serial engine
   typedef struct packed {
      logic txd;
      logic sclk;
      logic sfrm;
   } sp_lines_t;

   // Level driven on an unowned dedicated pin group
   localparam sp_lines_t SP_IDLE = '{txd: 1'b1, sclk: 1'b0, sfrm: 1'b0};

endpackage

// File: rtl/sport_ctl_reg.sv
module sport_ctl_reg #(
   parameter int unsigned ADDR_W   = 4,
   parameter logic [ADDR_W-1:0] CSR_ADDR = '0,
   parameter int unsigned UART_BIT = 12,
   parameter int unsigned SSP_BIT  = 18
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            sel,
   input  logic                            we,
   input  logic [ADDR_W-1:0]               addr,
   input  logic [sport_pin_pkg::CSR_W-1:0] wdata,
   output logic [sport_pin_pkg::CSR_W-1:0] rdata,
   output logic                            uart_ra,
   output logic                            ssp_ra
);
   logic hit;
   logic uart_q, ssp_q;

   assign hit = (addr == CSR_ADDR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         uart_q <= 1'b0;
         ssp_q  <= 1'b0;
      end else if (sel && we && hit) begin
         uart_q <= wdata[UART_BIT];
         ssp_q  <= wdata[SSP_BIT];
      end
   end

   always_comb begin
      rdata = '0;
      if (hit) begin
         rdata[UART_BIT] = uart_q;
         rdata[SSP_BIT]  = ssp_q;
      end
   end

   assign uart_ra = uart_q;
   assign ssp_ra  = ssp_q;
endmodule

// File: rtl/sport_p1_route.sv
module sport_p1_route (
   input  logic ra,
   input  logic sel_uart,
   input  logic uart_txd,
   input  logic sdlc_txd,
   input  logic pin_rx,
   input  logic gp_rx,
   output logic pin_tx,
   output logic pin_oe,
   output logic gp_tx,
   output logic uart_rxd,
   output logic sdlc_rxd,
   output logic uart_act,
   output logic sdlc_act
);
   logic uart_on_ded;

   assign uart_on_ded = !ra && sel_uart;
   assign uart_act    = ra || sel_uart;
   assign sdlc_act    = !uart_on_ded;

   assign pin_tx   = uart_on_ded ? uart_txd : sdlc_txd;
   assign pin_oe   = 1'b1;
   assign gp_tx    = uart_txd;
   assign sdlc_rxd = sdlc_act ? pin_rx : 1'b1;
   assign uart_rxd = ra ? gp_rx : (uart_on_ded ? pin_rx : 1'b1);
endmodule

// File: rtl/sport_p4_route.sv
module sport_p4_route
   import sport_pin_pkg::*;
(
   input  logic      ra,
   input  logic      codec_en,
   input  logic      ssp_en,
   input  sp_lines_t codec_o,
   input  sp_lines_t ssp_o,
   input  logic      pin_rx,
   input  logic      gp_rx,
   output sp_lines_t ded,
   output logic      ded_oe,
   output sp_lines_t gp_tx,
   output logic      codec_rxd,
   output logic      ssp_rxd,
   output logic      codec_act,
   output logic      ssp_act
);
   logic ssp_on_ded;

   assign codec_act  = ra || codec_en;
   assign ssp_on_ded = !ra && !codec_en && ssp_en;
   assign ssp_act    = ra || ssp_on_ded;

   always_comb begin
      if (codec_act)       ded = codec_o;
      else if (ssp_on_ded) ded = ssp_o;
      else                 ded = SP_IDLE;
   end

   assign ded_oe    = codec_act || ssp_on_ded;
   assign gp_tx     = ssp_o;
   assign codec_rxd = codec_act ? pin_rx : 1'b1;
   assign ssp_rxd   = ra ? gp_rx : (ssp_on_ded ? pin_rx : 1'b1);
endmodule

// File: rtl/sport_pin_router.sv
module sport_pin_router
   import sport_pin_pkg::*;
#(
   parameter int unsigned GPIO_W   = 16,
   parameter int unsigned ADDR_W   = 4,
   parameter logic [ADDR_W-1:0] CSR_ADDR = '0,
   parameter int unsigned UART_BIT = 12,
   parameter int unsigned SSP_BIT  = 18,
   parameter int unsigned UTX_PIN  = 14,
   parameter int unsigned URX_PIN  = 15,
   parameter int unsigned STX_PIN  = 10,
   parameter int unsigned SRX_PIN  = 11,
   parameter int unsigned SCK_PIN  = 12,
   parameter int unsigned SFM_PIN  = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_sel,
   input  logic              reg_we,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic              p1_sel_uart,
   input  logic              uart_txd,
   input  logic              sdlc_txd,
   output logic              uart_rxd,
   output logic              sdlc_rxd,
   output logic              p1_uart_act,
   output logic              p1_sdlc_act,
   output logic              p1_pin_tx,
   output logic              p1_pin_oe,
   input  logic              p1_pin_rx,
   input  logic              p4_codec_en,
   input  logic              p4_ssp_en,
   input  logic              codec_txd,
   input  logic              codec_sclk,
   input  logic              codec_sfrm,
   input  logic              ssp_txd,
   input  logic              ssp_sclk,
   input  logic              ssp_sfrm,
   output logic              codec_rxd,
   output logic              ssp_rxd,
   output logic              p4_codec_act,
   output logic              p4_ssp_act,
   output logic              p4_pin_tx,
   output logic              p4_pin_clk,
   output logic              p4_pin_frm,
   output logic              p4_pin_oe,
   input  logic              p4_pin_rx,
   input  logic [GPIO_W-1:0] gp_out_i,
   input  logic [GPIO_W-1:0] gp_oe_i,
   input  logic [GPIO_W-1:0] gp_in_i,
   output logic [GPIO_W-1:0] gp_out_o,
   output logic [GPIO_W-1:0] gp_oe_o,
   output logic [GPIO_W-1:0] gp_ovr_o
);
   localparam logic [GPIO_W-1:0] TAKEN_MASK =
      (GPIO_W'(1) << UTX_PIN) | (GPIO_W'(1) << URX_PIN) | (GPIO_W'(1) << STX_PIN) |
      (GPIO_W'(1) << SRX_PIN) | (GPIO_W'(1) << SCK_PIN) | (GPIO_W'(1) << SFM_PIN);

   // Elaboration-time parameter checks
   if (UART_BIT >= CSR_W || SSP_BIT >= CSR_W || UART_BIT == SSP_BIT) begin : g_bad_bits
      $error("flag bit positions must be distinct and inside the control word");
   end
   if (UTX_PIN >= GPIO_W || URX_PIN >= GPIO_W || STX_PIN >= GPIO_W ||
       SRX_PIN >= GPIO_W || SCK_PIN >= GPIO_W || SFM_PIN >= GPIO_W) begin : g_bad_range
      $error("a reassigned pin index lies outside the general-purpose bank");
   end
   if ($countones(TAKEN_MASK) != 6) begin : g_bad_overlap
      $error("reassigned pin indices must be distinct");
   end

   logic      uart_ra, ssp_ra;
   logic      p1_gp_tx;
   sp_lines_t codec_lines, ssp_lines, p4_ded, p4_gp;

   sport_ctl_reg #(
      .ADDR_W(ADDR_W), .CSR_ADDR(CSR_ADDR), .UART_BIT(UART_BIT), .SSP_BIT(SSP_BIT)
   ) u_ctl (
      .clk(clk), .rst_n(rst_n), .sel(reg_sel), .we(reg_we), .addr(reg_addr),
      .wdata(reg_wdata), .rdata(reg_rdata), .uart_ra(uart_ra), .ssp_ra(ssp_ra)
   );

   sport_p1_route u_p1 (
      .ra(uart_ra), .sel_uart(p1_sel_uart), .uart_txd(uart_txd), .sdlc_txd(sdlc_txd),
      .pin_rx(p1_pin_rx), .gp_rx(gp_in_i[URX_PIN]), .pin_tx(p1_pin_tx), .pin_oe(p1_pin_oe),
      .gp_tx(p1_gp_tx), .uart_rxd(uart_rxd), .sdlc_rxd(sdlc_rxd),
      .uart_act(p1_uart_act), .sdlc_act(p1_sdlc_act)
   );

   assign codec_lines = '{txd: codec_txd, sclk: codec_sclk, sfrm: codec_sfrm};
   assign ssp_lines   = '{txd: ssp_txd,   sclk: ssp_sclk,   sfrm: ssp_sfrm};

   sport_p4_route u_p4 (
      .ra(ssp_ra), .codec_en(p4_codec_en), .ssp_en(p4_ssp_en),
      .codec_o(codec_lines), .ssp_o(ssp_lines), .pin_rx(p4_pin_rx),
      .gp_rx(gp_in_i[SRX_PIN]), .ded(p4_ded), .ded_oe(p4_pin_oe), .gp_tx(p4_gp),
      .codec_rxd(codec_rxd), .ssp_rxd(ssp_rxd),
      .codec_act(p4_codec_act), .ssp_act(p4_ssp_act)
   );

   assign p4_pin_tx  = p4_ded.txd;
   assign p4_pin_clk = p4_ded.sclk;
   assign p4_pin_frm = p4_ded.sfrm;

   // Per-pin merge of engine lines into the general-purpose bank
   for (genvar i = 0; i < GPIO_W; i++) begin : g_pin
      if (i == UTX_PIN) begin : g_drv_u
         assign gp_ovr_o[i] = uart_ra;
         assign gp_out_o[i] = uart_ra ? p1_gp_tx : gp_out_i[i];
         assign gp_oe_o[i]  = uart_ra ? 1'b1 : gp_oe_i[i];
      end else if (i == URX_PIN) begin : g_rcv_u
         assign gp_ovr_o[i] = uart_ra;
         assign gp_out_o[i] = uart_ra ? 1'b0 : gp_out_i[i];
         assign gp_oe_o[i]  = uart_ra ? 1'b0 : gp_oe_i[i];
      end else if (i == STX_PIN || i == SCK_PIN || i == SFM_PIN) begin : g_drv_s
         logic line;
         if (i == STX_PIN) begin : g_tx
            assign line = p4_gp.txd;
         end else if (i == SCK_PIN) begin : g_ck
            assign line = p4_gp.sclk;
         end else begin : g_fm
            assign line = p4_gp.sfrm;
         end
         assign gp_ovr_o[i] = ssp_ra;
         assign gp_out_o[i] = ssp_ra ? line : gp_out_i[i];
         assign gp_oe_o[i]  = ssp_ra ? 1'b1 : gp_oe_i[i];
      end else if (i == SRX_PIN) begin : g_rcv_s
         assign gp_ovr_o[i] = ssp_ra;
         assign gp_out_o[i] = ssp_ra ? 1'b0 : gp_out_i[i];
         assign gp_oe_o[i]  = ssp_ra ? 1'b0 : gp_oe_i[i];
      end else begin : g_pass
         assign gp_ovr_o[i] = 1'b0;
         assign gp_out_o[i] = gp_out_i[i];
         assign gp_oe_o[i]  = gp_oe_i[i];
      end
   end
endmodule

// File: rtl/sport_pin_router_chk.sv
module sport_pin_router_chk #(
   parameter int unsigned GPIO_W   = 16,
   parameter int unsigned ADDR_W   = 4,
   parameter logic [ADDR_W-1:0] CSR_ADDR = '0,
   parameter int unsigned UART_BIT = 12,
   parameter int unsigned SSP_BIT  = 18,
   parameter int unsigned UTX_PIN  = 14,
   parameter int unsigned URX_PIN  = 15,
   parameter int unsigned STX_PIN  = 10,
   parameter int unsigned SRX_PIN  = 11,
   parameter int unsigned SCK_PIN  = 12,
   parameter int unsigned SFM_PIN  = 13
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_sel,
   input logic              reg_we,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [31:0]       reg_wdata,
   input logic              p1_sel_uart,
   input logic              uart_txd,
   input logic              sdlc_txd,
   input logic              uart_rxd,
   input logic              p1_uart_act,
   input logic              p1_sdlc_act,
   input logic              p1_pin_tx,
   input logic              p4_codec_en,
   input logic              codec_txd,
   input logic              ssp_txd,
   input logic              ssp_sclk,
   input logic              ssp_sfrm,
   input logic              ssp_rxd,
   input logic              p4_codec_act,
   input logic              p4_ssp_act,
   input logic              p4_pin_tx,
   input logic              p4_pin_clk,
   input logic              p4_pin_frm,
   input logic              p4_pin_oe,
   input logic [GPIO_W-1:0] gp_out_i,
   input logic [GPIO_W-1:0] gp_oe_i,
   input logic [GPIO_W-1:0] gp_in_i,
   input logic [GPIO_W-1:0] gp_out_o,
   input logic [GPIO_W-1:0] gp_oe_o,
   input logic [GPIO_W-1:0] gp_ovr_o
);
   logic wr_hit;
   assign wr_hit = reg_sel && reg_we && (reg_addr == CSR_ADDR);

   // R1
   reset_clear_chk: assert property (@(posedge clk) $rose(rst_n) |-> (gp_ovr_o == '0));

   // R2
   flag_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hit |=> (gp_ovr_o[UTX_PIN] == $past(reg_wdata[UART_BIT])) &&
                 (gp_ovr_o[STX_PIN] == $past(reg_wdata[SSP_BIT])));

   // R3
   flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_hit |=> $stable(gp_ovr_o));

   // R4
   p1_native_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!gp_ovr_o[UTX_PIN] && p1_sel_uart) |-> (p1_uart_act && !p1_sdlc_act && p1_pin_tx == uart_txd));

   // R5
   p1_moved_chk: assert property (@(posedge clk) disable iff (!rst_n)
      gp_ovr_o[UTX_PIN] |-> (gp_oe_o[UTX_PIN] && !gp_oe_o[URX_PIN] &&
                             gp_out_o[UTX_PIN] == uart_txd && uart_rxd == gp_in_i[URX_PIN] &&
                             p1_pin_tx == sdlc_txd));

   // R6
   p4_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
      p4_codec_en |-> (p4_codec_act && p4_pin_oe && p4_pin_tx == codec_txd &&
                       (p4_ssp_act == gp_ovr_o[STX_PIN])));

   // R7
   p4_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!p4_codec_act && !p4_ssp_act) |-> (p4_pin_tx && !p4_pin_clk && !p4_pin_frm && !p4_pin_oe));

   // R8
   p4_moved_chk: assert property (@(posedge clk) disable iff (!rst_n)
      gp_ovr_o[STX_PIN] |-> (p4_codec_act && gp_out_o[STX_PIN] == ssp_txd &&
                             gp_out_o[SCK_PIN] == ssp_sclk && gp_out_o[SFM_PIN] == ssp_sfrm &&
                             !gp_oe_o[SRX_PIN] && ssp_rxd == gp_in_i[SRX_PIN]));

   // R9
   pass_thru_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((((gp_out_o ^ gp_out_i) | (gp_oe_o ^ gp_oe_i)) & ~gp_ovr_o) == '0) &&
      ($countones(gp_ovr_o) == 2 * 32'(gp_ovr_o[UTX_PIN]) + 4 * 32'(gp_ovr_o[STX_PIN])));
endmodule

bind sport_pin_router sport_pin_router_chk #(
   .GPIO_W(GPIO_W), .ADDR_W(ADDR_W), .CSR_ADDR(CSR_ADDR),
   .UART_BIT(UART_BIT), .SSP_BIT(SSP_BIT),
   .UTX_PIN(UTX_PIN), .URX_PIN(URX_PIN), .STX_PIN(STX_PIN),
   .SRX_PIN(SRX_PIN), .SCK_PIN(SCK_PIN), .SFM_PIN(SFM_PIN)
) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_we(reg_we), .reg_addr(reg_addr),
   .reg_wdata(reg_wdata), .p1_sel_uart(p1_sel_uart), .uart_txd(uart_txd),
   .sdlc_txd(sdlc_txd), .uart_rxd(uart_rxd), .p1_uart_act(p1_uart_act),
   .p1_sdlc_act(p1_sdlc_act), .p1_pin_tx(p1_pin_tx), .p4_codec_en(p4_codec_en),
   .codec_txd(codec_txd), .ssp_txd(ssp_txd), .ssp_sclk(ssp_sclk), .ssp_sfrm(ssp_sfrm),
   .ssp_rxd(ssp_rxd), .p4_codec_act(p4_codec_act), .p4_ssp_act(p4_ssp_act),
   .p4_pin_tx(p4_pin_tx), .p4_pin_clk(p4_pin_clk), .p4_pin_frm(p4_pin_frm),
   .p4_pin_oe(p4_pin_oe), .gp_out_i(gp_out_i), .gp_oe_i(gp_oe_i), .gp_in_i(gp_in_i),
   .gp_out_o(gp_out_o), .gp_oe_o(gp_oe_o), .gp_ovr_o(gp_ovr_o)
);

// File: tb/sport_pin_router_tb.sv
module sport_pin_router_tb;
   localparam int GW = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic reg_sel = 1'b0, reg_we = 1'b0;
   logic [3:0] reg_addr = '0;
   logic [31:0] reg_wdata = '0, reg_rdata;
   logic p1_sel_uart = 0, uart_txd = 0, sdlc_txd = 0, p1_pin_rx = 0;
   logic uart_rxd, sdlc_rxd, p1_uart_act, p1_sdlc_act, p1_pin_tx, p1_pin_oe;
   logic p4_codec_en = 0, p4_ssp_en = 0, p4_pin_rx = 0;
   logic codec_txd = 0, codec_sclk = 0, codec_sfrm = 0, ssp_txd = 0, ssp_sclk = 0, ssp_sfrm = 0;
   logic codec_rxd, ssp_rxd, p4_codec_act, p4_ssp_act;
   logic p4_pin_tx, p4_pin_clk, p4_pin_frm, p4_pin_oe;
   logic [GW-1:0] gp_out_i = '0, gp_oe_i = '0, gp_in_i = '0;
   logic [GW-1:0] gp_out_o, gp_oe_o, gp_ovr_o;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   sport_pin_router u_dut (
      .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .p1_sel_uart(p1_sel_uart), .uart_txd(uart_txd), .sdlc_txd(sdlc_txd),
      .uart_rxd(uart_rxd), .sdlc_rxd(sdlc_rxd), .p1_uart_act(p1_uart_act),
      .p1_sdlc_act(p1_sdlc_act), .p1_pin_tx(p1_pin_tx), .p1_pin_oe(p1_pin_oe),
      .p1_pin_rx(p1_pin_rx), .p4_codec_en(p4_codec_en), .p4_ssp_en(p4_ssp_en),
      .codec_txd(codec_txd), .codec_sclk(codec_sclk), .codec_sfrm(codec_sfrm),
      .ssp_txd(ssp_txd), .ssp_sclk(ssp_sclk), .ssp_sfrm(ssp_sfrm),
      .codec_rxd(codec_rxd), .ssp_rxd(ssp_rxd), .p4_codec_act(p4_codec_act),
      .p4_ssp_act(p4_ssp_act), .p4_pin_tx(p4_pin_tx), .p4_pin_clk(p4_pin_clk),
      .p4_pin_frm(p4_pin_frm), .p4_pin_oe(p4_pin_oe), .p4_pin_rx(p4_pin_rx),
      .gp_out_i(gp_out_i), .gp_oe_i(gp_oe_i), .gp_in_i(gp_in_i),
      .gp_out_o(gp_out_o), .gp_oe_o(gp_oe_o), .gp_ovr_o(gp_ovr_o)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [3:0] a, input logic [31:0] d, input logic we);
      @(negedge clk);
      reg_sel = 1'b1; reg_we = we; reg_addr = a; reg_wdata = d;
      @(posedge clk);
      #1;
      reg_sel = 1'b0; reg_we = 1'b0; reg_addr = '0;
   endtask

   task automatic rd_chk(input string req, input logic [3:0] a, input logic [31:0] exp);
      reg_addr = a;
      #1;
      chk(req, reg_rdata, exp);
      reg_addr = '0;
      #1;
   endtask

   // Compare every output against values derived from the requirements
   task automatic sweep_chk(input bit fu, input bit fs);
      logic [5:0]  e1;
      logic [7:0]  e4;
      logic [GW-1:0] movr, eout, eoe;
      bit u_ded, s_ded, c_act, s_act;
      u_ded = !fu && p1_sel_uart;
      e1 = {u_ded ? uart_txd : sdlc_txd, 1'b1,
            fu ? gp_in_i[15] : (u_ded ? p1_pin_rx : 1'b1),
            !u_ded ? p1_pin_rx : 1'b1,
            fu | p1_sel_uart, !u_ded};
      chk(fu ? "R5 port1" : "R4 port1",
          32'({p1_pin_tx, p1_pin_oe, uart_rxd, sdlc_rxd, p1_uart_act, p1_sdlc_act}), 32'(e1));
      c_act = fs | p4_codec_en;
      s_ded = !fs && !p4_codec_en && p4_ssp_en;
      s_act = fs | s_ded;
      if (c_act)      e4[7:4] = {codec_txd, codec_sclk, codec_sfrm, 1'b1};
      else if (s_ded) e4[7:4] = {ssp_txd, ssp_sclk, ssp_sfrm, 1'b1};
      else            e4[7:4] = 4'b1000;
      e4[3:0] = {c_act ? p4_pin_rx : 1'b1,
                 fs ? gp_in_i[11] : (s_ded ? p4_pin_rx : 1'b1), c_act, s_act};
      chk(fs ? "R8 port4" : (c_act ? "R6 port4" : (s_ded ? "R6 port4" : "R7 port4")),
          32'({p4_pin_tx, p4_pin_clk, p4_pin_frm, p4_pin_oe, codec_rxd, ssp_rxd,
               p4_codec_act, p4_ssp_act}), 32'(e4));
      movr = (fu ? 16'hC000 : 16'h0) | (fs ? 16'h3C00 : 16'h0);
      eout = gp_out_i & ~movr;
      eoe  = gp_oe_i & ~movr;
      if (fu) begin eout[14] = uart_txd; eoe[14] = 1'b1; end
      if (fs) begin
         eout[10] = ssp_txd; eout[12] = ssp_sclk; eout[13] = ssp_sfrm;
         eoe[10] = 1'b1; eoe[12] = 1'b1; eoe[13] = 1'b1;
      end
      chk("R9 gpio merge", {gp_ovr_o, gp_out_o}, {movr, eout});
      chk(fs ? "R8 gpio enable" : (fu ? "R5 gpio enable" : "R9 gpio enable"),
          32'(gp_oe_o), 32'(eoe));
   endtask

   initial begin
      gp_out_i = 16'h1234; gp_oe_i = 16'hF0F0;
      repeat (3) @(posedge clk);
      #1;
      // R1 reset state
      rd_chk("R1 readback", 4'd0, 32'h0);
      chk("R1 override", 32'(gp_ovr_o), 32'h0);
      chk("R1 passthrough", {gp_out_o, gp_oe_o}, {gp_out_i, gp_oe_i});
      @(negedge clk);
      rst_n = 1'b1;

      // R2 write all ones, no effect before the edge
      @(negedge clk);
      reg_sel = 1'b1; reg_we = 1'b1; reg_addr = 4'd0; reg_wdata = 32'hFFFF_FFFF;
      #1;
      chk("R2 no early effect", reg_rdata, 32'h0);
      @(posedge clk);
      #1;
      reg_sel = 1'b0; reg_we = 1'b0;
      rd_chk("R2 flag positions", 4'd0, 32'h0004_1000);
      // R3 other address reads zero; write to other address and no-strobe ignored
      rd_chk("R3 other addr read", 4'd5, 32'h0);
      bus_wr(4'd3, 32'h0, 1'b1);
      rd_chk("R3 wrong addr write", 4'd0, 32'h0004_1000);
      bus_wr(4'd0, 32'h0, 1'b0);
      rd_chk("R3 no strobe", 4'd0, 32'h0004_1000);
      // R2 reserved bits alone leave flags clear
      bus_wr(4'd0, 32'hFFFB_EFFF, 1'b1);
      rd_chk("R2 reserved bits", 4'd0, 32'h0);
      bus_wr(4'd0, 32'h0000_1000, 1'b1);
      rd_chk("R2 uart only", 4'd0, 32'h0000_1000);

      // Sweep all flag settings against all inputs
      for (int f = 0; f < 4; f++) begin
         bus_wr(4'd0, (f[0] ? 32'h1000 : 32'h0) | (f[1] ? 32'h4_0000 : 32'h0), 1'b1);
         for (int s = 0; s < 64; s++) begin
            @(negedge clk);
            p1_sel_uart = s[0]; p4_codec_en = s[1]; p4_ssp_en = s[2];
            uart_txd = s[3]; sdlc_txd = ~s[3]; p1_pin_rx = s[4] ^ s[3];
            codec_txd = ~s[3]; codec_sclk = s[3]; codec_sfrm = ~s[4];
            ssp_txd = s[4]; ssp_sclk = ~s[4]; ssp_sfrm = s[3];
            p4_pin_rx = ~s[4];
            gp_in_i  = s[5] ? 16'hA5C3 : 16'h5A3C;
            gp_out_i = s[4] ? 16'h0FF0 : 16'hF00F;
            gp_oe_i  = s[3] ? 16'h3CC3 : 16'hC33C;
            #1;
            sweep_chk(f[0], f[1]);
         end
      end

      // R10 same-cycle response, no clock edge between change and sample
      bus_wr(4'd0, 32'h0, 1'b1);
      @(negedge clk);
      p1_sel_uart = 1'b1; uart_txd = 1'b0; sdlc_txd = 1'b1;
      p4_codec_en = 1'b0; p4_ssp_en = 1'b1; ssp_txd = 1'b0;
      #0.5;
      chk("R10 port1 follows select", 32'(p1_pin_tx), 32'(1'b0));
      p1_sel_uart = 1'b0;
      #0.5;
      chk("R10 port1 follows select", 32'(p1_pin_tx), 32'(1'b1));
      p4_codec_en = 1'b1; codec_txd = 1'b1;
      #0.5;
      chk("R10 port4 follows enable", 32'({p4_pin_tx, p4_ssp_act}), 32'(2'b10));

      // R1 reset clears flags set earlier
      bus_wr(4'd0, 32'h0004_1000, 1'b1);
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      rd_chk("R1 reset clears", 4'd0, 32'h0);
      chk("R1 reset override", 32'(gp_ovr_o), 32'h0);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule